// File: doc/BRIEF.md
# Breakpoint Acknowledge Responder

This block sits beside a processor as an emulation aid. It watches the bus for the special read cycle that the processor issues when it executes one of its eight breakpoint opcodes. The function code marks that cycle as CPU space, and address lines 19..16 carry space type 0. Address lines 4..2 give the breakpoint number. The block looks that number up in a local eight-entry table. If the entry is enabled, it terminates the cycle with a data acknowledge and drives the stored replacement opcode, which the processor then executes in place of the breakpoint. If the entry is disabled, it terminates with a bus error, which sends the processor into its illegal-instruction exception.

A small configuration port loads each entry's replacement word and enable bit. Each breakpoint has its own hit counter. A sticky event flag tells a host which breakpoint was reached most recently. All other bus cycles are left alone.

Control is a four-state machine. `ST_IDLE` waits for the address strobe. On the edge that decodes a claimed cycle it moves to `ST_GIVE_WORD` if the entry is enabled, or to `ST_GIVE_ERR` if it is disabled. An unclaimed strobe moves it to `ST_PASS`. Every non-idle state returns to `ST_IDLE` on the first edge at which the strobe is seen negated.

Top module: `bkpt_ack_responder`

## Requirements
- R1: A cycle is claimed only when, at a rising clock edge, `as_n`=0, `read`=1, `fcode`=3'b111 and `a_space`=4'h0. Any other cycle leaves `dack`, `berr` and `data_out` at 0 and changes no counter or event state.
- R2: The breakpoint number is `a_bpnum` (the processor's address lines 4..2). It selects the table entry, the hit counter and the reported event number.
- R3: For a claimed cycle whose entry is enabled, `dack`=1, `berr`=0 and `data_out` equals the entry's stored 16-bit word.
- R4: For a claimed cycle whose entry is disabled, `berr`=1, `dack`=0 and `data_out`=0. `dack` and `berr` are never both 1.
- R5: The termination is absent before the decoding edge and appears right after it. It stays constant while `as_n` stays 0, and it is removed by the first edge that samples `as_n`=1.
- R6: One strobe gives exactly one decode: a hit counter rises by one per claimed cycle however long `as_n` is held.
- R7: A configuration write (`cfg_we`=1 at an edge) loads `cfg_word` and `cfg_en` into entry `cfg_idx`, but only when `as_n`=1 at that edge. A write made while the strobe is low is dropped.
- R8: Each breakpoint has an 8-bit hit counter, read through `hit_sel`/`hit_count`. A claimed cycle adds one whether the entry is enabled or not, and the counter stops at 255.
- R9: A claimed cycle sets `evt_valid` and loads `evt_num` with its number. `evt_clear` clears `evt_valid`, and a hit at the same edge takes precedence over the clear.
- R10: After reset every entry is disabled with word 0, all counters read 0, `evt_valid`=0 and both terminations are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Address strobe, active low |
| read | input | 1 | 1 for a read cycle |
| fcode | input | 3 | Processor function code |
| a_space | input | 4 | Address lines 19..16 (CPU space type) |
| a_bpnum | input | 3 | Address lines 4..2 (breakpoint number) |
| dack | output | 1 | Data acknowledge termination |
| berr | output | 1 | Bus error termination |
| data_out | output | 16 | Replacement word, 0 when not acknowledging |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Table entry to write |
| cfg_word | input | 16 | Replacement word to store |
| cfg_en | input | 1 | Enable bit to store |
| hit_sel | input | 3 | Hit counter select |
| hit_count | output | 8 | Selected hit counter |
| evt_clear | input | 1 | Clears the event flag |
| evt_valid | output | 1 | Sticky breakpoint event flag |
| evt_num | output | 3 | Most recent breakpoint number |

## Verification
The properties assume that the bus inputs stay constant while `as_n` is low and that the strobe is high for at least one edge between cycles. This holds on a real processor bus, and it is what makes "held until the strobe negates" a well-defined check. The stimulus changes bus inputs only on falling edges and always releases the strobe for two full clocks before the next cycle. It sweeps all eight numbers with both enable patterns, every non-matching function code, every nonzero space type and write cycles. Counter stability is only claimed while `hit_sel` is unchanged, and the bench moves `hit_sel` only between bus cycles.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GIVE_WORD,
        ST_GIVE_ERR,
        ST_PASS
    } ack_state_e;

    localparam logic [2:0] FC_CPU_SPACE = 3'b111;
    localparam int         SPACE_W      = 4;
    localparam logic [SPACE_W-1:0] SPACE_BKPT = '0;

endpackage

// File: rtl/bkpt_decode.sv
module bkpt_decode
    import bkpt_pkg::*;
(
    input  logic               as_n,
    input  logic               read,
    input  logic [2:0]         fcode,
    input  logic [SPACE_W-1:0] a_space,
    output logic               claim,
    output logic               foreign
);

    logic strobe;
    logic is_bkpt;

    always_comb begin
        strobe  = !as_n;
        is_bkpt = read && (fcode == FC_CPU_SPACE) && (a_space == SPACE_BKPT);
        claim   = strobe && is_bkpt;
        foreign = strobe && !is_bkpt;
    end

endmodule

// File: rtl/bkpt_table.sv
module bkpt_table #(
    parameter int NUM_BP = 8,
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_enable,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_enable
);

    logic [WORD_W-1:0] word_q [NUM_BP];
    logic              en_q   [NUM_BP];

    for (genvar g = 0; g < NUM_BP; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
                en_q[g]   <= 1'b0;
            end else if (wr_go && (wr_idx == IDX_W'(g))) begin
                word_q[g] <= wr_word;
                en_q[g]   <= wr_enable;
            end
        end
    end

    always_comb begin
        rd_word   = word_q[rd_idx];
        rd_enable = en_q[rd_idx];
    end

endmodule

// File: rtl/bkpt_hitcnt.sv
module bkpt_hitcnt #(
    parameter int NUM_BP = 8,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic [IDX_W-1:0] sel,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_BP];

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (hit && (hit_idx == IDX_W'(g)) && (cnt_q[g] != CNT_MAX)) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end
    end

    assign count = cnt_q[sel];

endmodule

// File: rtl/bkpt_fsm.sv
module bkpt_fsm
    import bkpt_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              claim,
    input  logic              foreign,
    input  logic              entry_en,
    input  logic [WORD_W-1:0] entry_word,
    output logic              take,
    output logic              dack,
    output logic              berr,
    output logic [WORD_W-1:0] data_out
);

    ack_state_e        state_q;
    ack_state_e        state_d;
    logic [WORD_W-1:0] word_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (claim) begin
                    take    = 1'b1;
                    state_d = entry_en ? ST_GIVE_WORD : ST_GIVE_ERR;
                end else if (foreign) begin
                    state_d = ST_PASS;
                end
            end
            ST_GIVE_WORD: if (as_n) state_d = ST_IDLE;
            ST_GIVE_ERR:  if (as_n) state_d = ST_IDLE;
            ST_PASS:      if (as_n) state_d = ST_IDLE;
        endcase
    end

    // state register and captured word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                word_q <= entry_word;
            end
        end
    end

    // outputs
    always_comb begin
        dack     = 1'b0;
        berr     = 1'b0;
        data_out = '0;
        unique case (state_q)
            ST_GIVE_WORD: begin
                dack     = 1'b1;
                data_out = word_q;
            end
            ST_GIVE_ERR:  berr = 1'b1;
            ST_IDLE, ST_PASS: ;
        endcase
    end

endmodule

// File: rtl/bkpt_ack_responder.sv
module bkpt_ack_responder
    import bkpt_pkg::*;
#(
    parameter int NUM_BP = 8,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               as_n,
    input  logic               read,
    input  logic [2:0]         fcode,
    input  logic [SPACE_W-1:0] a_space,
    input  logic [IDX_W-1:0]   a_bpnum,
    output logic               dack,
    output logic               berr,
    output logic [WORD_W-1:0]  data_out,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [WORD_W-1:0]  cfg_word,
    input  logic               cfg_en,
    input  logic [IDX_W-1:0]   hit_sel,
    output logic [CNT_W-1:0]   hit_count,
    input  logic               evt_clear,
    output logic               evt_valid,
    output logic [IDX_W-1:0]   evt_num
);

    logic              claim;
    logic              foreign;
    logic              take;
    logic              entry_en;
    logic [WORD_W-1:0] entry_word;
    logic              cfg_go;

    assign cfg_go = cfg_we && as_n;

    bkpt_decode u_decode (
        .as_n    (as_n),
        .read    (read),
        .fcode   (fcode),
        .a_space (a_space),
        .claim   (claim),
        .foreign (foreign)
    );

    bkpt_table #(.NUM_BP(NUM_BP), .WORD_W(WORD_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (cfg_go),
        .wr_idx    (cfg_idx),
        .wr_word   (cfg_word),
        .wr_enable (cfg_en),
        .rd_idx    (a_bpnum),
        .rd_word   (entry_word),
        .rd_enable (entry_en)
    );

    bkpt_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_n       (as_n),
        .claim      (claim),
        .foreign    (foreign),
        .entry_en   (entry_en),
        .entry_word (entry_word),
        .take       (take),
        .dack       (dack),
        .berr       (berr),
        .data_out   (data_out)
    );

    bkpt_hitcnt #(.NUM_BP(NUM_BP), .CNT_W(CNT_W)) u_hitcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (take),
        .hit_idx (a_bpnum),
        .sel     (hit_sel),
        .count   (hit_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_num   <= '0;
        end else if (take) begin
            evt_valid <= 1'b1;
            evt_num   <= a_bpnum;
        end else if (evt_clear) begin
            evt_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/bkpt_ack_checker.sv
module bkpt_ack_checker
    import bkpt_pkg::*;
#(
    parameter int NUM_BP = 8,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(NUM_BP)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               as_n,
    input logic               read,
    input logic [2:0]         fcode,
    input logic [SPACE_W-1:0] a_space,
    input logic [IDX_W-1:0]   a_bpnum,
    input logic               dack,
    input logic               berr,
    input logic [WORD_W-1:0]  data_out,
    input logic [IDX_W-1:0]   hit_sel,
    input logic [CNT_W-1:0]   hit_count,
    input logic               evt_valid,
    input logic [IDX_W-1:0]   evt_num
);

    logic bus_claim;
    logic term;
    assign bus_claim = !as_n && read && (fcode == FC_CPU_SPACE) && (a_space == SPACE_BKPT);
    assign term      = dack || berr;

    // R1: a termination only starts after a matching cycle was sampled
    p_claim_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term) |-> $past(bus_claim));

    // R4: the two terminations are exclusive
    p_excl_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dack && berr));

    // R3: no data driven unless acknowledging
    p_data_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dack |-> (data_out == '0));

    // R5: held with stable data while the strobe stays low
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !as_n) |=> (term && $stable(dack) && $stable(data_out)));

    // R5: removed after the strobe is seen negated
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (term && as_n) |=> !term);

    // R8: counters never fall
    p_no_decrease_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(hit_sel) |-> (hit_count >= $past(hit_count)));

    // R8: saturation holds at the top value
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == {CNT_W{1'b1}}) |=> (!$stable(hit_sel) || hit_count == {CNT_W{1'b1}}));

    // R9: a new termination is always reflected in the event flag
    p_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term) |-> (evt_valid && evt_num == $past(a_bpnum)));

endmodule

bind bkpt_ack_responder bkpt_ack_checker #(
    .NUM_BP (NUM_BP),
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) u_bkpt_ack_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n      (as_n),
    .read      (read),
    .fcode     (fcode),
    .a_space   (a_space),
    .a_bpnum   (a_bpnum),
    .dack      (dack),
    .berr      (berr),
    .data_out  (data_out),
    .hit_sel   (hit_sel),
    .hit_count (hit_count),
    .evt_valid (evt_valid),
    .evt_num   (evt_num)
);

// File: tb/test_bkpt_ack_responder.sv
module test_bkpt_ack_responder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        read = 1'b1;
    logic [2:0]  fcode = 3'b000;
    logic [3:0]  a_space = 4'h0;
    logic [2:0]  a_bpnum = 3'd0;
    logic        dack;
    logic        berr;
    logic [15:0] data_out;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [15:0] cfg_word = 16'h0;
    logic        cfg_en = 1'b0;
    logic [2:0]  hit_sel = 3'd0;
    logic [7:0]  hit_count;
    logic        evt_clear = 1'b0;
    logic        evt_valid;
    logic [2:0]  evt_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_word [8];
    bit          m_en   [8];
    int          m_cnt  [8];
    bit          m_evt;
    int          m_num;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_ack_responder i_bkpt_ack_responder (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .read(read), .fcode(fcode),
        .a_space(a_space), .a_bpnum(a_bpnum), .dack(dack), .berr(berr),
        .data_out(data_out), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_word(cfg_word), .cfg_en(cfg_en), .hit_sel(hit_sel),
        .hit_count(hit_count), .evt_clear(evt_clear), .evt_valid(evt_valid),
        .evt_num(evt_num)
    );

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [15:0] w, input bit en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_word = w; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        m_word[idx] = w;
        m_en[idx]   = en;
    endtask

    task automatic check_counts(input string req);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            hit_sel = 3'(k);
            #1;
            chk(req, hit_count == 8'(m_cnt[k]), hit_count, m_cnt[k]);
        end
    endtask

    // one bus cycle; hold = number of edges the strobe stays low
    task automatic bus_cycle(input logic [2:0] f, input logic r, input logic [3:0] sp,
                             input int n, input int hold, input bit clr_at_decode);
        bit claimed;
        claimed = (f == 3'b111) && r && (sp == 4'h0);
        @(negedge clk);
        fcode = f; read = r; a_space = sp; a_bpnum = 3'(n); as_n = 1'b0;
        evt_clear = clr_at_decode;
        #1;
        chk("R5 no early termination", !dack && !berr, {dack, berr}, 0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            evt_clear = 1'b0;
            if (i == 0) begin
                if (claimed) begin
                    if (m_cnt[n] < 255) m_cnt[n]++;
                    m_evt = 1'b1;
                    m_num = n;
                end else if (clr_at_decode) begin
                    m_evt = 1'b0;
                end
            end
            if (claimed && m_en[n]) begin
                chk("R3 enabled entry gives word", dack && !berr && data_out == m_word[n],
                    {dack, berr, data_out}, {2'b10, m_word[n]});
            end else if (claimed) begin
                chk("R4 disabled entry gives bus error", !dack && berr && data_out == 16'h0,
                    {dack, berr, data_out}, {2'b01, 16'h0});
            end else begin
                chk("R1 unclaimed cycle ignored", !dack && !berr && data_out == 16'h0,
                    {dack, berr, data_out}, 0);
            end
            if (i == 0) begin
                chk("R9 event flag", evt_valid == m_evt, evt_valid, m_evt);
                if (m_evt) chk("R2 event number", evt_num == 3'(m_num), evt_num, m_num);
            end
        end
        as_n = 1'b1;
        @(negedge clk);
        chk("R5 release after strobe negation", !dack && !berr, {dack, berr}, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_word[k] = 16'h0; m_en[k] = 1'b0; m_cnt[k] = 0;
        end
        m_evt = 1'b0; m_num = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 reset terminations", !dack && !berr && data_out == 16'h0, {dack, berr, data_out}, 0);
        chk("R10 reset event", !evt_valid, evt_valid, 0);
        check_counts("R10 reset counters");
        bus_cycle(3'b111, 1'b1, 4'h0, 3, 2, 1'b0);   // R10: entries start disabled

        // R2 R3 R4: two complementary enable patterns over all numbers
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < 8; n++)
                cfg_write(n, 16'h4A00 + 16'(n * 16'h0111) + 16'(p * 16'h8000), bit'((n + p) % 2));
            for (int n = 0; n < 8; n++)
                bus_cycle(3'b111, 1'b1, 4'h0, n, 2 + n % 3, 1'b0);
        end
        check_counts("R8 counts after sweep");

        // R1: non-matching function codes, space types, write cycles
        @(negedge clk); evt_clear = 1'b1; @(negedge clk); evt_clear = 1'b0; m_evt = 1'b0;
        for (int f = 0; f < 7; f++)  bus_cycle(3'(f), 1'b1, 4'h0, 1, 2, 1'b0);
        for (int s = 1; s < 16; s++) bus_cycle(3'b111, 1'b1, 4'(s), 2, 2, 1'b0);
        for (int n = 0; n < 8; n++)  bus_cycle(3'b111, 1'b0, 4'h0, n, 2, 1'b0);
        chk("R1 no event from ignored cycles", !evt_valid, evt_valid, 0);
        check_counts("R1 counts unchanged");

        // R6: long strobe counts once
        bus_cycle(3'b111, 1'b1, 4'h0, 6, 7, 1'b0);
        hit_sel = 3'd6; #1;
        chk("R6 one hit per strobe", hit_count == 8'(m_cnt[6]), hit_count, m_cnt[6]);

        // R7: writes while the strobe is low are dropped
        cfg_write(2, 16'h1234, 1'b1);
        @(negedge clk);
        fcode = 3'b111; read = 1'b1; a_space = 4'h0; a_bpnum = 3'd2; as_n = 1'b0;
        cfg_we = 1'b1; cfg_idx = 3'd2; cfg_word = 16'hDEAD; cfg_en = 1'b0;
        @(negedge clk);
        cfg_idx = 3'd7; cfg_word = 16'hBEEF; cfg_en = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; as_n = 1'b1;
        m_cnt[2]++; m_evt = 1'b1; m_num = 2;
        repeat (2) @(negedge clk);
        bus_cycle(3'b111, 1'b1, 4'h0, 2, 2, 1'b0);  // expects 16'h1234, enabled
        bus_cycle(3'b111, 1'b1, 4'h0, 7, 2, 1'b0);  // entry 7 unchanged
        chk("R7 entry 2 kept", m_word[2] == 16'h1234, m_word[2], 16'h1234);

        // R9: clear alone, and clear colliding with a hit
        @(negedge clk); evt_clear = 1'b1; @(negedge clk); evt_clear = 1'b0; m_evt = 1'b0;
        #1;
        chk("R9 clear alone", !evt_valid, evt_valid, 0);
        bus_cycle(3'b111, 1'b1, 4'h0, 4, 2, 1'b1);
        chk("R9 hit wins over clear", evt_valid && evt_num == 3'd4, {evt_valid, evt_num}, {1'b1, 3'd4});

        // R8: saturation
        for (int i = 0; i < 260; i++) bus_cycle(3'b111, 1'b1, 4'h0, 5, 1, 1'b0);
        hit_sel = 3'd5; #1;
        chk("R8 saturates at 255", hit_count == 8'd255, hit_count, 255);
        check_counts("R8 final counts");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule